// File: doc/BRIEF.md
# Variable-Length Instruction Alignment Queue

This block sits between a 32-bit instruction memory port and an instruction decoder. The fetch side writes whole 32-bit words into a small parcel buffer that holds four 16-bit parcels. The decode side is handed at most one complete instruction per cycle. An instruction is either a single 16-bit parcel or a 48-bit group made of an opcode parcel and a 32-bit immediate. Because a 48-bit instruction can straddle two fetch words, the block joins its parcels and shows no valid instruction (a bubble) until the last parcel has arrived. Fetch and decode therefore run at their own pace.

A registered issue controller classifies the head of the buffer into one of four states:
- `HEAD_EMPTY`: no parcels are held.
- `HEAD_SHORT`: a 16-bit instruction is ready.
- `HEAD_LONG_WAIT`: a 48-bit head is still missing parcels.
- `HEAD_LONG_READY`: all three parcels of a 48-bit head are present.

Every cycle the next state is worked out from the parcel count and the head parcel that will hold after this cycle's write, pop and flush. The named transitions are:
- *drain*: any state to `HEAD_EMPTY` when the count reaches zero or a flush occurs.
- *arrive-short*: to `HEAD_SHORT` when the new head decodes as 16-bit.
- *arrive-long*: to `HEAD_LONG_WAIT` when the new head decodes as 48-bit with fewer than three parcels.
- *complete*: `HEAD_LONG_WAIT` to `HEAD_LONG_READY` when a write brings the count to three or more.
- *advance*: after a pop, the state of the following instruction.

Top module: `instr_align_queue`

## Requirements
- R1: After reset, `issue_valid_o` is 0 and `fetch_full_o` is 0.
- R2: A head parcel whose bits [15:14] are not 2'b00 issues as a 16-bit instruction. It appears as `issue_instr_o = {parcel, 32'h0}` with `issue_long_o = 0`.
- R3: A head parcel whose bits [15:14] are 2'b00 issues as a 48-bit instruction. It appears as `issue_instr_o = {opcode, imm_hi, imm_lo}` with `issue_long_o = 1`, and only once all three parcels are held.
- R4: While a 48-bit head is missing parcels, `issue_valid_o` is 0 (a bubble).
- R5: Within a written word, bits [31:16] are the earlier parcel in program order and bits [15:0] the later one.
- R6: `fetch_full_o` is 1 exactly when more than two of the four parcel slots are occupied.
- R7: A write while `fetch_full_o` is 1 is dropped and changes neither the buffer nor any later output.
- R8: A write and a pop in the same cycle are both applied, and instruction order is preserved.
- R9: A synchronous flush empties the buffer, so the next cycle shows `issue_valid_o = 0` and `fetch_full_o = 0`. A write in the flush cycle is discarded.
- R10: An instruction is consumed only when `issue_valid_o` and `issue_ready_i` are both 1. Otherwise the issued instruction is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Synchronous buffer flush |
| fetch_wr_i | input | 1 | Write enable for a fetch word |
| fetch_word_i | input | 32 | Fetch word; the upper half is the earlier parcel |
| fetch_full_o | output | 1 | No room for another fetch word |
| issue_ready_i | input | 1 | Decoder takes the presented instruction |
| issue_valid_o | output | 1 | A complete instruction is presented |
| issue_instr_o | output | 48 | Instruction, left-aligned |
| issue_long_o | output | 1 | Presented instruction is 48 bits |

## Verification
The bench drives a 48-bit instruction whose opcode and immediate are split across two words. A design that issues early would show garbage immediate bits instead of the expected bubble, and one that swaps the halves of a word would scramble both the parcel order and the length decode. The bench writes while full and later drains the buffer. A design that overwrote slots or counted the dropped word would release extra or corrupted instructions. A flush with a simultaneous write, and a long mixed stream with concurrent writes and pops, expose occupancy arithmetic that misses one of the two updates or keeps the discarded word.

// File: rtl/ialign_pkg.sv
package ialign_pkg;
    localparam int PARCEL_W = 16;
    localparam int WORD_W   = 2 * PARCEL_W;
    localparam int INSTR_W  = 3 * PARCEL_W;

    typedef logic [PARCEL_W-1:0] parcel_t;

    typedef enum logic [1:0] {
        HEAD_EMPTY      = 2'd0,
        HEAD_SHORT      = 2'd1,
        HEAD_LONG_WAIT  = 2'd2,
        HEAD_LONG_READY = 2'd3
    } head_state_e;
endpackage

// File: rtl/ialign_len_decode.sv
module ialign_len_decode
    import ialign_pkg::*;
(
    input  parcel_t parcel_i,
    output logic    is_long_o
);
    // Opcode class 2'b00 in the top two bits marks a 48-bit instruction.
    always_comb begin
        is_long_o = (parcel_i[PARCEL_W-1 -: 2] == 2'b00);
    end
endmodule

// File: rtl/ialign_parcel_store.sv
module ialign_parcel_store
    import ialign_pkg::*;
#(
    parameter  int SLOTS = 4,
    localparam int PTR_W = $clog2(SLOTS),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               push_i,
    input  logic [WORD_W-1:0]  push_word_i,
    input  logic [CNT_W-1:0]   pop_n_i,
    output logic [CNT_W-1:0]   count_o,
    output logic [INSTR_W-1:0] window_o,
    output logic [CNT_W-1:0]   nxt_count_o,
    output parcel_t            nxt_head_o
);
    parcel_t            slots_q [SLOTS];
    logic [PTR_W-1:0]   rd_ptr_q;
    logic [CNT_W-1:0]   count_q;
    logic [PTR_W-1:0]   wr_idx_a;
    logic [PTR_W-1:0]   wr_idx_b;
    logic [PTR_W-1:0]   new_head_idx;

    always_comb begin
        wr_idx_a     = rd_ptr_q + PTR_W'(count_q);
        wr_idx_b     = wr_idx_a + PTR_W'(1);
        new_head_idx = rd_ptr_q + PTR_W'(pop_n_i);
    end

    // Three-parcel window starting at the head, head parcel in the top bits.
    always_comb begin
        for (int k = 0; k < 3; k++) begin
            window_o[INSTR_W-1-k*PARCEL_W -: PARCEL_W] = slots_q[rd_ptr_q + PTR_W'(k)];
        end
    end

    // Occupancy and head parcel after this cycle's flush, pop and push.
    always_comb begin
        if (flush_i) begin
            nxt_count_o = '0;
        end else begin
            nxt_count_o = count_q + (push_i ? CNT_W'(2) : CNT_W'(0)) - pop_n_i;
        end
        if (pop_n_i < count_q) begin
            nxt_head_o = slots_q[new_head_idx];
        end else begin
            nxt_head_o = push_word_i[WORD_W-1 -: PARCEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            count_q  <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                slots_q[i] <= '0;
            end
        end else if (flush_i) begin
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_i) begin
                slots_q[wr_idx_a] <= push_word_i[WORD_W-1 -: PARCEL_W];
                slots_q[wr_idx_b] <= push_word_i[PARCEL_W-1:0];
            end
            rd_ptr_q <= new_head_idx;
            count_q  <= nxt_count_o;
        end
    end

    assign count_o = count_q;

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(SLOTS));

    p_push_has_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (count_q <= CNT_W'(SLOTS - 2)));

    p_pop_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop_n_i <= count_q);

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (count_q == '0));
endmodule

// File: rtl/ialign_issue_fsm.sv
module ialign_issue_fsm
    import ialign_pkg::*;
#(
    parameter  int SLOTS = 4,
    localparam int CNT_W = $clog2(SLOTS) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ready_i,
    input  logic [INSTR_W-1:0] window_i,
    input  logic [CNT_W-1:0]   nxt_count_i,
    input  logic               nxt_long_i,
    output logic               valid_o,
    output logic               long_o,
    output logic [INSTR_W-1:0] instr_o,
    output logic [CNT_W-1:0]   pop_n_o,
    output head_state_e        state_o
);
    head_state_e state_q;
    head_state_e state_d;

    // Next-state selection from the post-update buffer view.
    always_comb begin
        if (nxt_count_i == '0) begin
            state_d = HEAD_EMPTY;
        end else if (!nxt_long_i) begin
            state_d = HEAD_SHORT;
        end else if (nxt_count_i >= CNT_W'(3)) begin
            state_d = HEAD_LONG_READY;
        end else begin
            state_d = HEAD_LONG_WAIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HEAD_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode per state.
    always_comb begin
        valid_o = 1'b0;
        long_o  = 1'b0;
        instr_o = '0;
        pop_n_o = '0;
        unique case (state_q)
            HEAD_EMPTY: begin
            end
            HEAD_SHORT: begin
                valid_o = 1'b1;
                instr_o = {window_i[INSTR_W-1 -: PARCEL_W], {(INSTR_W-PARCEL_W){1'b0}}};
                pop_n_o = ready_i ? CNT_W'(1) : CNT_W'(0);
            end
            HEAD_LONG_WAIT: begin
            end
            HEAD_LONG_READY: begin
                valid_o = 1'b1;
                long_o  = 1'b1;
                instr_o = window_i;
                pop_n_o = ready_i ? CNT_W'(3) : CNT_W'(0);
            end
            default: begin
            end
        endcase
    end

    assign state_o = state_q;

    p_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HEAD_LONG_WAIT) |-> !valid_o);

    p_long_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        long_o |-> valid_o);
endmodule

// File: rtl/instr_align_queue.sv
module instr_align_queue
    import ialign_pkg::*;
#(
    parameter  int SLOTS = 4,
    localparam int CNT_W = $clog2(SLOTS) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_i,
    input  logic                fetch_wr_i,
    input  logic [WORD_W-1:0]   fetch_word_i,
    output logic                fetch_full_o,
    input  logic                issue_ready_i,
    output logic                issue_valid_o,
    output logic [INSTR_W-1:0]  issue_instr_o,
    output logic                issue_long_o
);
    logic               push;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   nxt_count;
    logic [CNT_W-1:0]   pop_n;
    logic [INSTR_W-1:0] window;
    parcel_t            nxt_head;
    logic               nxt_long;
    head_state_e        state;

    always_comb begin
        fetch_full_o = (count > CNT_W'(SLOTS - 2));
        push         = fetch_wr_i && !fetch_full_o && !flush_i;
    end

    ialign_parcel_store #(.SLOTS(SLOTS)) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .push_i      (push),
        .push_word_i (fetch_word_i),
        .pop_n_i     (pop_n),
        .count_o     (count),
        .window_o    (window),
        .nxt_count_o (nxt_count),
        .nxt_head_o  (nxt_head)
    );

    ialign_len_decode i_len (
        .parcel_i  (nxt_head),
        .is_long_o (nxt_long)
    );

    ialign_issue_fsm #(.SLOTS(SLOTS)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_i     (issue_ready_i),
        .window_i    (window),
        .nxt_count_i (nxt_count),
        .nxt_long_i  (nxt_long),
        .valid_o     (issue_valid_o),
        .long_o      (issue_long_o),
        .instr_o     (issue_instr_o),
        .pop_n_o     (pop_n),
        .state_o     (state)
    );

    p_long_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && issue_long_o) |-> (count >= CNT_W'(3)));

    p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!issue_valid_o && !fetch_full_o));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && !issue_ready_i && !flush_i) |=>
            (issue_valid_o && $stable(issue_instr_o) && $stable(issue_long_o)));

    p_drop_full_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_wr_i && fetch_full_o && !flush_i && !(issue_valid_o && issue_ready_i))
            |=> (count == $past(count)));

    p_empty_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HEAD_EMPTY) |-> (count == '0));
endmodule

// File: tb/test_instr_align_queue.sv
module test_instr_align_queue;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        fetch_wr_i = 1'b0;
    logic [31:0] fetch_word_i = '0;
    logic        fetch_full_o;
    logic        issue_ready_i = 1'b0;
    logic        issue_valid_o;
    logic [47:0] issue_instr_o;
    logic        issue_long_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [15:0] model_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_align_queue i_instr_align_queue (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush_i),
        .fetch_wr_i    (fetch_wr_i),
        .fetch_word_i  (fetch_word_i),
        .fetch_full_o  (fetch_full_o),
        .issue_ready_i (issue_ready_i),
        .issue_valid_o (issue_valid_o),
        .issue_instr_o (issue_instr_o),
        .issue_long_o  (issue_long_o)
    );

    function automatic bit head_long();
        return model_q.size() > 0 && model_q[0][15:14] == 2'b00;
    endfunction

    function automatic bit exp_valid();
        if (model_q.size() == 0) return 1'b0;
        if (!head_long()) return 1'b1;
        return model_q.size() >= 3;
    endfunction

    task automatic check1(input string tag, input string what, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then update the model at the rising edge.
    task automatic step(input logic wr, input logic [31:0] word, input logic rdy, input logic fl, input string tag);
        bit ev;
        bit ef;
        logic [47:0] ei;
        @(negedge clk);
        fetch_wr_i    = wr;
        fetch_word_i  = word;
        issue_ready_i = rdy;
        flush_i       = fl;
        #1;
        ev = exp_valid();
        ef = model_q.size() > 2;
        check1(tag, "valid", 48'(issue_valid_o), 48'(ev));
        check1(tag, "full", 48'(fetch_full_o), 48'(ef));
        if (ev) begin
            ei = head_long() ? {model_q[0], model_q[1], model_q[2]} : {model_q[0], 32'h0};
            check1(tag, "instr", issue_instr_o, ei);
            check1(tag, "long", 48'(issue_long_o), 48'(head_long()));
        end
        @(posedge clk);
        if (fl) begin
            model_q.delete();
        end else begin
            if (ev && rdy) begin
                if (head_long()) begin
                    void'(model_q.pop_front());
                    void'(model_q.pop_front());
                    void'(model_q.pop_front());
                end else begin
                    void'(model_q.pop_front());
                end
            end
            if (wr && !ef) begin
                model_q.push_back(word[31:16]);
                model_q.push_back(word[15:0]);
            end
        end
    endtask

    task automatic t_reset_r1();
        step(1'b0, 32'h0, 1'b0, 1'b0, "R1");
    endtask

    task automatic t_short_order_r2_r5();
        step(1'b1, 32'h4001_8002, 1'b1, 1'b0, "R5");
        step(1'b0, 32'h0, 1'b1, 1'b0, "R2");
        step(1'b0, 32'h0, 1'b1, 1'b0, "R5");
        step(1'b0, 32'h0, 1'b1, 1'b0, "R2");
    endtask

    task automatic t_long_straddle_r3_r4();
        step(1'b1, 32'h0123_AAAA, 1'b1, 1'b0, "R4");
        step(1'b0, 32'h0, 1'b1, 1'b0, "R4");
        step(1'b1, 32'hBBBB_8005, 1'b1, 1'b0, "R4");
        step(1'b0, 32'h0, 1'b1, 1'b0, "R3");
        step(1'b0, 32'h0, 1'b1, 1'b0, "R3");
        step(1'b0, 32'h0, 1'b1, 1'b0, "R3");
    endtask

    task automatic t_full_drop_r6_r7();
        step(1'b1, 32'hC111_C222, 1'b0, 1'b0, "R6");
        step(1'b1, 32'hC333_C444, 1'b0, 1'b0, "R6");
        step(1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, "R7");
        step(1'b1, 32'hFACE_FEED, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 5; i++) step(1'b0, 32'h0, 1'b1, 1'b0, "R7");
    endtask

    task automatic t_hold_r10();
        step(1'b1, 32'h0777_1234, 1'b0, 1'b0, "R10");
        step(1'b1, 32'h5678_9999, 1'b0, 1'b0, "R10");
        step(1'b0, 32'h0, 1'b0, 1'b0, "R10");
        step(1'b0, 32'h0, 1'b0, 1'b0, "R10");
        for (int i = 0; i < 3; i++) step(1'b0, 32'h0, 1'b1, 1'b0, "R10");
    endtask

    task automatic t_concurrent_r8();
        step(1'b1, 32'h9001_9002, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 6; i++) step(1'b1, {16'hA000 + 16'(i), 16'hB000 + 16'(i)}, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 4; i++) step(1'b0, 32'h0, 1'b1, 1'b0, "R8");
    endtask

    task automatic t_flush_r9();
        step(1'b1, 32'h0ABC_1111, 1'b0, 1'b0, "R9");
        step(1'b1, 32'h2222_7333, 1'b0, 1'b0, "R9");
        step(1'b1, 32'h6666_7777, 1'b1, 1'b1, "R9");
        step(1'b0, 32'h0, 1'b1, 1'b0, "R9");
        step(1'b1, 32'h4444_5555, 1'b1, 1'b0, "R9");
        step(1'b0, 32'h0, 1'b1, 1'b0, "R9");
        step(1'b0, 32'h0, 1'b1, 1'b0, "R9");
    endtask

    task automatic t_mixed_r8();
        logic [31:0] lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[3], lfsr, lfsr[7] | lfsr[9], (lfsr[15:11] == 5'd0), "R8");
        end
        for (int i = 0; i < 6; i++) step(1'b0, 32'h0, 1'b1, 1'b0, "R8");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_short_order_r2_r5();
        t_long_straddle_r3_r4();
        t_full_drop_r6_r7();
        t_hold_r10();
        t_concurrent_r8();
        t_flush_r9();
        t_mixed_r8();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule